// File: doc/BRIEF.md
# Rotary-Encoder Parameter Control Unit

This block turns three hand-operated rotary knobs, each with a push switch, into the registered settings that drive an oscilloscope front end and display. Every raw input line is brought into the clock domain and debounced. Each knob's A/B pair goes through a quadrature state machine that emits one signed step per full detent. The steps and presses then update a single settings register bank. All values saturate at their ends, except the menu highlight, which wraps.

Knob 0 normally steps the time-base index, and a press swaps it to the trigger level. Knob 1 normally steps the vertical scale, and a press swaps it to the vertical offset. Knob 2 walks a six-row menu, and its press acts on the highlighted row. When a cursor row is highlighted, rotation of knobs 0 and 1 moves that cursor instead of their usual parameters.

Named states:
- **Quadrature phases** (`{A,B}`): `PH_11` (rest), `PH_01`, `PH_00`, `PH_10`.
  - Clockwise transitions: `PH_11→PH_01→PH_00→PH_10→PH_11`.
  - Counter-clockwise transitions: the same path in reverse.
  - Diagonal jumps are invalid.
- **Knob 0 modes:** `K0_TIMEBASE` and `K0_TRIGLVL`, swapped by a press.
- **Knob 1 modes:** `K1_VSCALE` and `K1_VOFFSET`, swapped by a press.
- **Menu rows:** `ROW_COUPLING` (0), `ROW_TRIGMODE` (1), `ROW_RUN` (2), `ROW_EDGE` (3), `ROW_CUR_A` (4), `ROW_CUR_B` (5).
- **Trigger modes:** `TM_AUTO` (0), `TM_NORMAL` (1), `TM_SINGLE` (2).

Top module: `scope_knob_ctrl`

## Requirements
- R1: A/B inputs and push switches are synchronised and only accepted once they differ from the held level for AB_STABLE or SW_STABLE consecutive cycles. A shorter glitch causes no step and no press.
- R2: One full clockwise detent on `{A,B}` (11→01→00→10→11) gives +1, and the reverse sequence gives −1. A detent abandoned part way, or a diagonal jump (both bits changing together), gives no step.
- R3: Knob 0 in `K0_TIMEBASE` (the reset mode) steps `timebase_idx`, which saturates at 0 and TB_STEPS−1. A knob 0 press swaps between `K0_TIMEBASE` and `K0_TRIGLVL`.
- R4: In `K0_TRIGLVL`, knob 0 steps `trig_level` (a signed 8-bit code) by ±1 per detent, saturating at −128 and +127.
- R5: Knob 1 in `K1_VSCALE` (the reset mode) steps `vscale_idx` over 0..9, saturating at both ends. Index 0 is 10 mV/div and index 9 is 10 V/div, following a 1-2-5 sequence. A knob 1 press swaps to `K1_VOFFSET`.
- R6: In `K1_VOFFSET`, knob 1 steps `voffset` (a signed 8-bit code) by ±1, saturating at −128 and +127.
- R7: Knob 2 rotation moves `menu_row` through rows 0..5 in the order listed above, wrapping from 5 to 0 and from 0 to 5.
- R8: A knob 2 press acts on the highlighted row as follows:
  - row 0 toggles `coupling_ac` (0 = DC, 1 = AC);
  - row 2 toggles `running` (1 = run);
  - row 3 toggles `edge_falling` (0 = rising).
- R9: A knob 2 press on row 1 cycles `trig_mode` through 0 (auto), 1 (normal), 2 (single), then back to 0.
- R10: On a cursor row, knob 0 steps the highlighted cursor by 1 per detent and knob 1 steps it by CUR_COARSE, saturating at 0 and CUR_MAX. In this case the time base, trigger level, vertical scale and offset do not change. A knob 2 press on a cursor row changes nothing.
- R11: After reset, every output is 0 except `running`, which is 1. Both knobs start in their first mode.
- R12: In a cycle with no step and no press, no setting changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 3 | Raw A line of knobs 2..0 |
| enc_b | input | 3 | Raw B line of knobs 2..0 |
| enc_sw_n | input | 3 | Raw push switch of knobs 2..0, low when pressed |
| timebase_idx | output | TB_W (5) | Time-base index |
| trig_level | output | 8 | Signed trigger level code |
| vscale_idx | output | 4 | Vertical scale index 0..9 |
| voffset | output | 8 | Signed vertical offset code |
| menu_row | output | 3 | Highlighted menu row 0..5 |
| coupling_ac | output | 1 | 1 = AC coupling |
| trig_mode | output | 2 | 0 auto, 1 normal, 2 single |
| running | output | 1 | 1 = acquisition running |
| edge_falling | output | 1 | 1 = falling-edge trigger |
| cursor_a | output | CUR_W (9) | Cursor A position |
| cursor_b | output | CUR_W (9) | Cursor B position |

## Verification
The assertions rely on two assumptions about the inputs. First, A/B lines and switches idle high through reset, so the quadrature machine starts in `PH_11` with an empty sub-count. Second, each knob's lines change slowly compared with the debounce windows. The stimulus honours both. It holds every quadrature phase and every switch level for several cycles longer than the matching filter window. It changes only one knob at a time. It injects deliberate glitches only where rejecting them is the thing under test.

// File: rtl/knob_pkg.sv
package knob_pkg;

    typedef enum logic [1:0] {PH_11, PH_01, PH_00, PH_10} quad_ph_e;

    typedef enum logic [1:0] {STEP_NONE, STEP_UP, STEP_DN} step_e;

    typedef enum logic [2:0] {
        ROW_COUPLING = 3'd0,
        ROW_TRIGMODE = 3'd1,
        ROW_RUN      = 3'd2,
        ROW_EDGE     = 3'd3,
        ROW_CUR_A    = 3'd4,
        ROW_CUR_B    = 3'd5
    } menu_row_e;

    typedef enum logic [1:0] {TM_AUTO = 2'd0, TM_NORMAL = 2'd1, TM_SINGLE = 2'd2} trig_mode_e;

    typedef enum logic {K0_TIMEBASE, K0_TRIGLVL} k0_mode_e;
    typedef enum logic {K1_VSCALE, K1_VOFFSET} k1_mode_e;

    localparam int VSCALE_STEPS = 10;

    function automatic int clampi(int v, int lo, int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic quad_ph_e phase_of(logic a, logic b);
        quad_ph_e p;
        unique case ({a, b})
            2'b11:   p = PH_11;
            2'b01:   p = PH_01;
            2'b00:   p = PH_00;
            default: p = PH_10;
        endcase
        return p;
    endfunction

    function automatic quad_ph_e cw_of(quad_ph_e p);
        quad_ph_e n;
        unique case (p)
            PH_11:   n = PH_01;
            PH_01:   n = PH_00;
            PH_00:   n = PH_10;
            default: n = PH_11;
        endcase
        return n;
    endfunction

    function automatic quad_ph_e ccw_of(quad_ph_e p);
        quad_ph_e n;
        unique case (p)
            PH_11:   n = PH_10;
            PH_10:   n = PH_00;
            PH_00:   n = PH_01;
            default: n = PH_11;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/knob_filter.sv
module knob_filter #(
    parameter int   STABLE_CYC = 4,
    parameter logic RST_LVL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {2{RST_LVL}};
            run_q  <= '0;
            level  <= RST_LVL;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == level) begin
                run_q <= '0;
            end else if (run_q == CW'(STABLE_CYC - 1)) begin
                level <= sync_q[1];
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R1: a new level is only ever the synchronised input value
    a_r1_level_from_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> (level == $past(sync_q[1])));

    // R1: a level change needs the full run of differing samples
    a_r1_full_run: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> ($past(run_q) == CW'(STABLE_CYC - 1)));

endmodule

// File: rtl/quad_decoder.sv
module quad_decoder
    import knob_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic step_up,
    output logic step_dn
);
    quad_ph_e          ph_q, ph_d, ph_in;
    logic signed [3:0] cnt_q, cnt_d;
    step_e             step_q, step_d;

    always_comb begin
        ph_in  = phase_of(a, b);
        ph_d   = ph_in;
        cnt_d  = cnt_q;
        step_d = STEP_NONE;
        if (ph_in != ph_q) begin
            if (ph_in == cw_of(ph_q)) begin
                cnt_d = cnt_q + 4'sd1;
            end else if (ph_in == ccw_of(ph_q)) begin
                cnt_d = cnt_q - 4'sd1;
            end else begin
                cnt_d = '0;
            end
            if (ph_in == PH_11) begin
                if (cnt_d == 4'sd4) begin
                    step_d = STEP_UP;
                end else if (cnt_d == -4'sd4) begin
                    step_d = STEP_DN;
                end
                cnt_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= PH_11;
            cnt_q  <= '0;
            step_q <= STEP_NONE;
        end else begin
            ph_q   <= ph_d;
            cnt_q  <= cnt_d;
            step_q <= step_d;
        end
    end

    always_comb begin
        step_up = (step_q == STEP_UP);
        step_dn = (step_q == STEP_DN);
    end

    // R2: the rest phase never carries a partial detent
    a_r2_cnt_home: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == PH_11) |-> (cnt_q == 4'sd0));

    // R2: away from rest the sub-count stays within one detent
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q >= -4'sd3) && (cnt_q <= 4'sd3));

    // R2: steps are only reported on arrival at rest
    a_r2_step_home: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up || step_dn) |-> (ph_q == PH_11));

    // R2: at most one direction at a time
    a_r2_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn}));

endmodule

// File: rtl/knob_settings.sv
module knob_settings
    import knob_pkg::*;
#(
    parameter  int TB_STEPS   = 20,
    parameter  int CUR_W      = 9,
    parameter  int CUR_MAX    = 239,
    parameter  int CUR_COARSE = 8,
    localparam int TB_W       = $clog2(TB_STEPS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              step_up,
    input  logic [2:0]              step_dn,
    input  logic [2:0]              press,
    output logic [TB_W-1:0]         timebase_idx,
    output logic signed [7:0]       trig_level,
    output logic [3:0]              vscale_idx,
    output logic signed [7:0]       voffset,
    output logic [2:0]              menu_row,
    output logic                    coupling_ac,
    output logic [1:0]              trig_mode,
    output logic                    running,
    output logic                    edge_falling,
    output logic [CUR_W-1:0]        cursor_a,
    output logic [CUR_W-1:0]        cursor_b
);
    k0_mode_e          k0_q, k0_d;
    k1_mode_e          k1_q, k1_d;
    menu_row_e         row_q, row_d;
    trig_mode_e        tm_q, tm_d;
    logic [TB_W-1:0]   tb_q, tb_d;
    logic signed [7:0] lvl_q, lvl_d, off_q, off_d;
    logic [3:0]        vs_q, vs_d;
    logic              cpl_q, cpl_d, run_q, run_d, edg_q, edg_d;
    logic [CUR_W-1:0]  ca_q, ca_d, cb_q, cb_d;

    int  dir0, dir1, dir2, cur_delta;
    logic any_evt;

    always_comb begin
        dir0 = step_up[0] ? 1 : (step_dn[0] ? -1 : 0);
        dir1 = step_up[1] ? 1 : (step_dn[1] ? -1 : 0);
        dir2 = step_up[2] ? 1 : (step_dn[2] ? -1 : 0);
        cur_delta = dir0 + dir1 * CUR_COARSE;

        k0_d = k0_q;   k1_d = k1_q;   row_d = row_q;  tm_d = tm_q;
        tb_d = tb_q;   lvl_d = lvl_q; vs_d = vs_q;    off_d = off_q;
        cpl_d = cpl_q; run_d = run_q; edg_d = edg_q;
        ca_d = ca_q;   cb_d = cb_q;

        // rotation of knobs 0 and 1
        unique case (row_q)
            ROW_CUR_A: ca_d = CUR_W'(clampi(int'(ca_q) + cur_delta, 0, CUR_MAX));
            ROW_CUR_B: cb_d = CUR_W'(clampi(int'(cb_q) + cur_delta, 0, CUR_MAX));
            default: begin
                if (k0_q == K0_TRIGLVL)
                    lvl_d = 8'(clampi(int'(lvl_q) + dir0, -128, 127));
                else
                    tb_d = TB_W'(clampi(int'(tb_q) + dir0, 0, TB_STEPS - 1));
                if (k1_q == K1_VOFFSET)
                    off_d = 8'(clampi(int'(off_q) + dir1, -128, 127));
                else
                    vs_d = 4'(clampi(int'(vs_q) + dir1, 0, VSCALE_STEPS - 1));
            end
        endcase

        // presses on knobs 0 and 1 swap their modes
        if (press[0]) k0_d = (k0_q == K0_TIMEBASE) ? K0_TRIGLVL : K0_TIMEBASE;
        if (press[1]) k1_d = (k1_q == K1_VSCALE) ? K1_VOFFSET : K1_VSCALE;

        // knob 2 press acts on the highlighted row
        if (press[2]) begin
            unique case (row_q)
                ROW_COUPLING: cpl_d = ~cpl_q;
                ROW_TRIGMODE: begin
                    unique case (tm_q)
                        TM_AUTO:   tm_d = TM_NORMAL;
                        TM_NORMAL: tm_d = TM_SINGLE;
                        default:   tm_d = TM_AUTO;
                    endcase
                end
                ROW_RUN:  run_d = ~run_q;
                ROW_EDGE: edg_d = ~edg_q;
                default:  ;
            endcase
        end

        // knob 2 rotation walks the menu with wrap
        if (dir2 != 0)
            row_d = menu_row_e'(3'((int'(row_q) + dir2 + 6) % 6));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k0_q <= K0_TIMEBASE; k1_q <= K1_VSCALE; row_q <= ROW_COUPLING;
            tm_q <= TM_AUTO;     tb_q <= '0;        lvl_q <= '0;
            vs_q <= '0;          off_q <= '0;       cpl_q <= 1'b0;
            run_q <= 1'b1;       edg_q <= 1'b0;     ca_q <= '0;
            cb_q <= '0;
        end else begin
            k0_q <= k0_d;   k1_q <= k1_d;   row_q <= row_d;
            tm_q <= tm_d;   tb_q <= tb_d;   lvl_q <= lvl_d;
            vs_q <= vs_d;   off_q <= off_d; cpl_q <= cpl_d;
            run_q <= run_d; edg_q <= edg_d; ca_q <= ca_d;
            cb_q <= cb_d;
        end
    end

    always_comb begin
        timebase_idx = tb_q;
        trig_level   = lvl_q;
        vscale_idx   = vs_q;
        voffset      = off_q;
        menu_row     = row_q;
        coupling_ac  = cpl_q;
        trig_mode    = tm_q;
        running      = run_q;
        edge_falling = edg_q;
        cursor_a     = ca_q;
        cursor_b     = cb_q;
        any_evt      = |{step_up, step_dn, press};
    end

    a_r3_tb_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tb_q) < TB_STEPS);

    a_r5_vs_range: assert property (@(posedge clk) disable iff (!rst_n)
        vs_q < 4'(VSCALE_STEPS));

    a_r7_row_range: assert property (@(posedge clk) disable iff (!rst_n)
        row_q <= ROW_CUR_B);

    a_r9_mode_valid: assert property (@(posedge clk) disable iff (!rst_n)
        tm_q != 2'd3);

    a_r10_cursor_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ca_q) <= CUR_MAX) && (int'(cb_q) <= CUR_MAX));

    // R10: on a cursor row the knob 0/1 parameters stay put
    a_r10_params_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (row_q == ROW_CUR_A || row_q == ROW_CUR_B) |=>
        ($stable(tb_q) && $stable(lvl_q) && $stable(vs_q) && $stable(off_q)));

    a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !any_evt |=> ($stable(tb_q) && $stable(lvl_q) && $stable(vs_q) &&
                      $stable(off_q) && $stable(row_q) && $stable(tm_q) &&
                      $stable(cpl_q) && $stable(run_q) && $stable(edg_q) &&
                      $stable(ca_q) && $stable(cb_q) && $stable(k0_q) && $stable(k1_q)));

endmodule

// File: rtl/scope_knob_ctrl.sv
module scope_knob_ctrl
    import knob_pkg::*;
#(
    parameter  int AB_STABLE  = 64,
    parameter  int SW_STABLE  = 2_000_000,
    parameter  int TB_STEPS   = 20,
    parameter  int CUR_W      = 9,
    parameter  int CUR_MAX    = 239,
    parameter  int CUR_COARSE = 8,
    localparam int TB_W       = $clog2(TB_STEPS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            enc_a,
    input  logic [2:0]            enc_b,
    input  logic [2:0]            enc_sw_n,
    output logic [TB_W-1:0]       timebase_idx,
    output logic signed [7:0]     trig_level,
    output logic [3:0]            vscale_idx,
    output logic signed [7:0]     voffset,
    output logic [2:0]            menu_row,
    output logic                  coupling_ac,
    output logic [1:0]            trig_mode,
    output logic                  running,
    output logic                  edge_falling,
    output logic [CUR_W-1:0]      cursor_a,
    output logic [CUR_W-1:0]      cursor_b
);
    localparam int KNOBS = 3;

    logic [KNOBS-1:0] a_f, b_f, sw_f, sw_f_q, press, step_up, step_dn;

    for (genvar k = 0; k < KNOBS; k++) begin : g_knob
        knob_filter #(.STABLE_CYC(AB_STABLE), .RST_LVL(1'b1)) u_fa (
            .clk(clk), .rst_n(rst_n), .raw(enc_a[k]), .level(a_f[k]));
        knob_filter #(.STABLE_CYC(AB_STABLE), .RST_LVL(1'b1)) u_fb (
            .clk(clk), .rst_n(rst_n), .raw(enc_b[k]), .level(b_f[k]));
        knob_filter #(.STABLE_CYC(SW_STABLE), .RST_LVL(1'b1)) u_fs (
            .clk(clk), .rst_n(rst_n), .raw(enc_sw_n[k]), .level(sw_f[k]));
        quad_decoder u_dec (
            .clk(clk), .rst_n(rst_n), .a(a_f[k]), .b(b_f[k]),
            .step_up(step_up[k]), .step_dn(step_dn[k]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sw_f_q <= '1;
        else        sw_f_q <= sw_f;
    end

    assign press = sw_f_q & ~sw_f;

    // R1: a press is a single-cycle event
    a_r1_press_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        |press |=> ((press & $past(press)) == '0));

    knob_settings #(
        .TB_STEPS(TB_STEPS), .CUR_W(CUR_W), .CUR_MAX(CUR_MAX), .CUR_COARSE(CUR_COARSE)
    ) u_set (
        .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn), .press(press),
        .timebase_idx(timebase_idx), .trig_level(trig_level), .vscale_idx(vscale_idx),
        .voffset(voffset), .menu_row(menu_row), .coupling_ac(coupling_ac),
        .trig_mode(trig_mode), .running(running), .edge_falling(edge_falling),
        .cursor_a(cursor_a), .cursor_b(cursor_b));

endmodule

// File: tb/scope_knob_ctrl_test.sv
`timescale 1ns/1ps
module scope_knob_ctrl_test;
    localparam int AB_DB = 4, SW_DB = 16, TB_STEPS = 20;
    localparam int CUR_W = 9, CUR_MAX = 239, CUR_COARSE = 8;
    localparam int TB_W = $clog2(TB_STEPS);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;
    logic [2:0] enc_a, enc_b, enc_sw_n;
    logic [TB_W-1:0] timebase_idx;
    logic signed [7:0] trig_level, voffset;
    logic [3:0] vscale_idx;
    logic [2:0] menu_row;
    logic coupling_ac, running, edge_falling;
    logic [1:0] trig_mode;
    logic [CUR_W-1:0] cursor_a, cursor_b;

    scope_knob_ctrl #(.AB_STABLE(AB_DB), .SW_STABLE(SW_DB), .TB_STEPS(TB_STEPS),
        .CUR_W(CUR_W), .CUR_MAX(CUR_MAX), .CUR_COARSE(CUR_COARSE)) uut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_sw_n(enc_sw_n),
        .timebase_idx(timebase_idx), .trig_level(trig_level), .vscale_idx(vscale_idx),
        .voffset(voffset), .menu_row(menu_row), .coupling_ac(coupling_ac),
        .trig_mode(trig_mode), .running(running), .edge_falling(edge_falling),
        .cursor_a(cursor_a), .cursor_b(cursor_b));

    typedef struct {
        string tag;
        int tb, lvl, vs, off, row, cpl, mode, run, edg, ca, cb;
    } exp_t;

    exp_t q[$];
    int checks = 0, failures = 0;
    bit done = 0;

    // requirement-level model
    int m_tb = 0, m_lvl = 0, m_vs = 0, m_off = 0, m_row = 0, m_cpl = 0;
    int m_mode = 0, m_run = 1, m_edg = 0, m_ca = 0, m_cb = 0;
    bit m_k0alt = 0, m_k1alt = 0;

    function automatic int clip(int v, int lo, int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic model_step(int k, int dir);
        bit cur = (m_row == 4) || (m_row == 5);
        int d;
        if (k == 2) begin
            m_row = (m_row + dir + 6) % 6;
        end else if (cur) begin
            d = (k == 0) ? dir : dir * CUR_COARSE;
            if (m_row == 4) m_ca = clip(m_ca + d, 0, CUR_MAX);
            else            m_cb = clip(m_cb + d, 0, CUR_MAX);
        end else if (k == 0) begin
            if (m_k0alt) m_lvl = clip(m_lvl + dir, -128, 127);
            else         m_tb  = clip(m_tb + dir, 0, TB_STEPS - 1);
        end else begin
            if (m_k1alt) m_off = clip(m_off + dir, -128, 127);
            else         m_vs  = clip(m_vs + dir, 0, 9);
        end
    endtask

    task automatic model_press(int k);
        if (k == 0) m_k0alt = !m_k0alt;
        else if (k == 1) m_k1alt = !m_k1alt;
        else begin
            case (m_row)
                0: m_cpl = 1 - m_cpl;
                1: m_mode = (m_mode + 1) % 3;
                2: m_run = 1 - m_run;
                3: m_edg = 1 - m_edg;
                default: ;
            endcase
        end
    endtask

    task automatic set_ab(int k, logic a, logic b);
        @(negedge clk);
        enc_a[k] = a;
        enc_b[k] = b;
        repeat (AB_DB + 4) @(negedge clk);
    endtask

    task automatic rotate(int k, int n);
        int cnt = (n < 0) ? -n : n;
        for (int i = 0; i < cnt; i++) begin
            if (n > 0) begin
                set_ab(k, 0, 1); set_ab(k, 0, 0); set_ab(k, 1, 0); set_ab(k, 1, 1);
            end else begin
                set_ab(k, 1, 0); set_ab(k, 0, 0); set_ab(k, 0, 1); set_ab(k, 1, 1);
            end
            model_step(k, (n > 0) ? 1 : -1);
        end
    endtask

    task automatic press_knob(int k);
        @(negedge clk);
        enc_sw_n[k] = 1'b0;
        repeat (SW_DB + 6) @(negedge clk);
        enc_sw_n[k] = 1'b1;
        repeat (SW_DB + 6) @(negedge clk);
        model_press(k);
    endtask

    task automatic push(string tag);
        exp_t e;
        repeat (12) @(negedge clk);
        e.tag = tag; e.tb = m_tb; e.lvl = m_lvl; e.vs = m_vs; e.off = m_off;
        e.row = m_row; e.cpl = m_cpl; e.mode = m_mode; e.run = m_run;
        e.edg = m_edg; e.ca = m_ca; e.cb = m_cb;
        q.push_back(e);
        repeat (2) @(negedge clk);
    endtask

    task automatic cmp(string tag, string field, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, field, act, exp);
        end
    endtask

    // monitor: pops expected snapshots and compares against the outputs
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.tag, "timebase_idx", int'(timebase_idx), e.tb);
            cmp(e.tag, "trig_level",   int'(trig_level),   e.lvl);
            cmp(e.tag, "vscale_idx",   int'(vscale_idx),   e.vs);
            cmp(e.tag, "voffset",      int'(voffset),      e.off);
            cmp(e.tag, "menu_row",     int'(menu_row),     e.row);
            cmp(e.tag, "coupling_ac",  int'(coupling_ac),  e.cpl);
            cmp(e.tag, "trig_mode",    int'(trig_mode),    e.mode);
            cmp(e.tag, "running",      int'(running),      e.run);
            cmp(e.tag, "edge_falling", int'(edge_falling), e.edg);
            cmp(e.tag, "cursor_a",     int'(cursor_a),     e.ca);
            cmp(e.tag, "cursor_b",     int'(cursor_b),     e.cb);
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        enc_a = '1; enc_b = '1; enc_sw_n = '1;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        push("R11");

        rotate(0, 3);    push("R3");
        rotate(0, -5);   push("R3");   // clamps at 0
        rotate(0, 25);   push("R3");   // clamps at TB_STEPS-1

        // R1: short glitch on A gives no step
        @(negedge clk); enc_a[0] = 1'b0;
        repeat (AB_DB - 2) @(negedge clk);
        enc_a[0] = 1'b1;
        push("R1");
        // R1: short switch glitch gives no mode swap; knob 0 still steps time base
        @(negedge clk); enc_sw_n[0] = 1'b0;
        repeat (SW_DB / 2) @(negedge clk);
        enc_sw_n[0] = 1'b1;
        repeat (SW_DB + 6) @(negedge clk);
        rotate(0, -1);   push("R1");

        press_knob(0);
        rotate(0, 130);  push("R4");   // clamps at 127
        rotate(0, -260); push("R4");   // clamps at -128
        rotate(0, 3);    push("R4");
        press_knob(0);
        rotate(0, -1);   push("R3");

        // R2: abandoned detent
        set_ab(0, 0, 1); set_ab(0, 1, 1);
        push("R2");
        // R2: diagonal jumps
        set_ab(0, 0, 0); set_ab(0, 1, 1);
        push("R2");
        // R2: jump in the middle breaks a detent
        set_ab(0, 0, 1); set_ab(0, 1, 0); set_ab(0, 1, 1);
        push("R2");

        rotate(1, 12);   push("R5");   // clamps at 9
        rotate(1, -3);   push("R5");
        press_knob(1);
        rotate(1, 140);  push("R6");   // clamps at 127
        rotate(1, -3);   push("R6");

        press_knob(2);   push("R8");   // coupling
        rotate(2, 1);
        press_knob(2);   push("R9");
        press_knob(2);   push("R9");
        press_knob(2);   push("R9");   // back to auto
        rotate(2, 1);
        press_knob(2);   push("R8");   // run/pause
        rotate(2, 1);
        press_knob(2);   push("R8");   // edge
        rotate(2, -4);   push("R7");   // wraps to 5
        rotate(2, 1);    push("R7");   // wraps to 0
        rotate(2, -2);   push("R7");   // row 4

        rotate(0, 5);    push("R10");
        rotate(1, 3);    push("R10");
        rotate(1, -10);  push("R10");  // clamps at 0
        rotate(1, 40);   push("R10");  // clamps at CUR_MAX
        press_knob(2);   push("R10");  // no effect on cursor row
        rotate(2, 1);
        rotate(0, -3);   push("R10");
        rotate(1, 2);    push("R10");
        rotate(0, 1);    push("R10");

        repeat (20) @(negedge clk);
        push("R12");
        while (q.size() > 0) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule